// File: doc/BRIEF.md
# Chained Descriptor DMA Controller

This block is a single-channel DMA engine that moves words between a peripheral stream and a memory port. Each transfer is set by three parameters: a start index, a stride (modify) added after every word, and a count of words still to move. Software writes these through a small register port and starts the engine with an enable bit. In standalone mode the engine runs exactly one transfer. In chained mode it reads its parameters from memory at the address in a chain pointer register. Each of these four-word control blocks names the next block and carries its own direction bit, so one chain can mix reads from memory and writes to memory.

The memory port and the peripheral stream respond in the same cycle, so the engine makes one memory access in every cycle while it is busy. A one-cycle interrupt pulse marks the end of a standalone transfer or of a whole chain. Software sees a busy flag, and the engine ignores register writes while it is working.

Top module: `chain_dma`

## Requirements
- R1: After reset, busy and irq are low and all five registers read back as zero.
- R2: Register addresses are 0 index, 1 modify, 2 count, 3 chain pointer and 4 control. Control bit 0 is enable, bit 1 selects chained mode, and bit 2 is the standalone direction (1 = peripheral to memory). While idle, a written value reads back unchanged on reg_rdata.
- R3: While idle, a control write that takes enable from 0 to 1 starts a transfer. A standalone transfer makes exactly count accesses, at addresses index + k*modify for k = 0..count-1, one per cycle.
- R4: With direction 1, each word taken from per_rdata (per_rd pulses) is written to memory. With direction 0, each word read from memory appears on per_wdata with a per_wr pulse.
- R5: While busy, writes to any register are ignored. The modify value read back after the transfer is the one programmed before it started.
- R6: After a transfer completes, writing control with enable still 1, without first clearing it, starts nothing.
- R7: irq is a single-cycle pulse in the first cycle busy is low after completion. A standalone start with count 0 completes at once, with one irq and no memory access.
- R8: In chained mode the engine reads four consecutive words from the chain pointer: +0 holds the next pointer with the direction in bit 0 (1 = write to memory), +1 the count, +2 the modify and +3 the index. The first data access comes in the cycle right after the fourth read.
- R9: Each descriptor's direction bit applies to its own words. A nonzero next pointer (bit 0 masked) causes the next fetch with no idle gap. A zero next pointer ends the chain, and irq pulses only once, at the end of the chain.
- R10: A chained descriptor with count 0 moves no data, and its four reads are followed directly by the next descriptor's fetch.
- R11: A chained start with chain pointer 0 completes at once, with one irq and no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for reg_addr |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, same cycle |
| per_rd | output | 1 | Word taken from the peripheral |
| per_rdata | input | DW | Peripheral source word |
| per_wr | output | 1 | Word delivered to the peripheral |
| per_wdata | output | DW | Peripheral sink word |
| busy | output | 1 | Transfer or fetch in progress |
| irq | output | 1 | Completion pulse |

## Verification
The checker tests several rules on every cycle. irq is a lone pulse and is raised only while idle. Peripheral strobes always match the direction of the memory access. A fourth descriptor read with a nonzero count leads straight into data transfer, and with a zero count it does not. A modify write during transfer leaves the stride unchanged. Only the bench scenarios can show the things that need the full picture: the address sequences, the data actually moved in each direction, the ordering of a mixed-direction chain with a skipped descriptor, and the enable-edge rule across consecutive transfers.

// File: rtl/dma_pkg.sv
package dma_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_XFER} dma_st_e;

    localparam logic [2:0] RA_INDEX  = 3'd0;
    localparam logic [2:0] RA_MODIFY = 3'd1;
    localparam logic [2:0] RA_COUNT  = 3'd2;
    localparam logic [2:0] RA_CHAIN  = 3'd3;
    localparam logic [2:0] RA_CTRL   = 3'd4;
endpackage

// File: rtl/dma_step.sv
// Address and count stepping for one transferred word.
module dma_step #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic [AW-1:0] idx,
    input  logic [AW-1:0] mdf,
    input  logic [CW-1:0] cnt,
    output logic [AW-1:0] idx_nx,
    output logic [CW-1:0] cnt_nx,
    output logic          last
);
    assign idx_nx = idx + mdf;
    assign cnt_nx = cnt - CW'(1);
    assign last   = (cnt == CW'(1));
endmodule

// File: rtl/dma_desc_split.sv
// Splits the first descriptor word into next pointer and direction.
module dma_desc_split #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic [DW-1:0] word,
    output logic [AW-1:0] nptr,
    output logic          wr_mem
);
    assign nptr   = {word[AW-1:1], 1'b0};
    assign wr_mem = word[0];

    generate
        if (DW > AW) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^word[DW-1:AW];
        end
    endgenerate
endmodule

// File: rtl/chain_dma.sv
module chain_dma #(
    parameter int AW = 16,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          per_rd,
    input  logic [DW-1:0] per_rdata,
    output logic          per_wr,
    output logic [DW-1:0] per_wdata,
    output logic          busy,
    output logic          irq
);
    import dma_pkg::*;

    typedef struct packed {
        dma_st_e       st;
        logic [AW-1:0] idx;
        logic [AW-1:0] mdf;
        logic [CW-1:0] cnt;
        logic [AW-1:0] cp;
        logic [AW-1:0] nxt;
        logic [1:0]    wsel;
        logic          en;
        logic          chain;
        logic          dir;
        logic          irq;
    } dma_state_t;

    dma_state_t q, d;

    logic [AW-1:0] idx_nx;
    logic [CW-1:0] cnt_nx;
    logic          last;
    logic [AW-1:0] dsc_nptr;
    logic          dsc_wr;
    logic          unused_top;

    assign unused_top = ^{reg_wdata, mem_rdata};

    dma_step #(.AW(AW), .CW(CW)) u_step (
        .idx(q.idx), .mdf(q.mdf), .cnt(q.cnt),
        .idx_nx(idx_nx), .cnt_nx(cnt_nx), .last(last)
    );

    dma_desc_split #(.AW(AW), .DW(DW)) u_split (
        .word(mem_rdata), .nptr(dsc_nptr), .wr_mem(dsc_wr)
    );

    always_comb begin
        d         = q;
        d.irq     = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.idx;
        mem_wdata = per_rdata;
        per_rd    = 1'b0;
        per_wr    = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (reg_we) begin
                    case (reg_addr)
                        RA_INDEX:  d.idx = reg_wdata[AW-1:0];
                        RA_MODIFY: d.mdf = reg_wdata[AW-1:0];
                        RA_COUNT:  d.cnt = reg_wdata[CW-1:0];
                        RA_CHAIN:  d.cp  = reg_wdata[AW-1:0];
                        RA_CTRL: begin
                            d.en    = reg_wdata[0];
                            d.chain = reg_wdata[1];
                            d.dir   = reg_wdata[2];
                            if (reg_wdata[0] && !q.en) begin
                                if (reg_wdata[1]) begin
                                    if (q.cp == '0) begin
                                        d.irq = 1'b1;
                                    end else begin
                                        d.st   = ST_FETCH;
                                        d.wsel = 2'd0;
                                    end
                                end else if (q.cnt == '0) begin
                                    d.irq = 1'b1;
                                end else begin
                                    d.st = ST_XFER;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = q.cp + AW'(q.wsel);
                d.wsel   = q.wsel + 2'd1;
                case (q.wsel)
                    2'd0: begin
                        d.nxt = dsc_nptr;
                        d.dir = dsc_wr;
                    end
                    2'd1: d.cnt = mem_rdata[CW-1:0];
                    2'd2: d.mdf = mem_rdata[AW-1:0];
                    default: begin
                        d.idx = mem_rdata[AW-1:0];
                        if (q.cnt != '0) begin
                            d.st = ST_XFER;
                        end else if (q.nxt != '0) begin
                            d.cp = q.nxt;
                        end else begin
                            d.st  = ST_IDLE;
                            d.irq = 1'b1;
                        end
                    end
                endcase
            end
            ST_XFER: begin
                mem_req = 1'b1;
                mem_we  = q.dir;
                per_rd  = q.dir;
                per_wr  = !q.dir;
                d.idx   = idx_nx;
                d.cnt   = cnt_nx;
                if (last) begin
                    if (q.chain && q.nxt != '0) begin
                        d.st   = ST_FETCH;
                        d.cp   = q.nxt;
                        d.wsel = 2'd0;
                    end else begin
                        d.st  = ST_IDLE;
                        d.irq = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_INDEX:  reg_rdata = DW'(q.idx);
            RA_MODIFY: reg_rdata = DW'(q.mdf);
            RA_COUNT:  reg_rdata = DW'(q.cnt);
            RA_CHAIN:  reg_rdata = DW'(q.cp);
            RA_CTRL:   reg_rdata = DW'({q.dir, q.chain, q.en});
            default:   reg_rdata = '0;
        endcase
    end

    assign per_wdata = mem_rdata;
    assign busy      = (q.st != ST_IDLE);
    assign irq       = q.irq;
endmodule

// File: rtl/dma_chk.sv
module dma_chk #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          irq,
    input logic          mem_req,
    input logic          mem_we,
    input logic          per_rd,
    input logic          per_wr,
    input logic          reg_we,
    input logic [2:0]    reg_addr,
    input logic          in_fetch,
    input logic          in_xfer,
    input logic [1:0]    wsel,
    input logic [CW-1:0] cnt,
    input logic [AW-1:0] mdf
);
    // R7
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R7
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy);
    // R4
    dir_tomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_rd |-> (mem_req && mem_we && !per_wr));
    // R4
    dir_toper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_wr |-> (mem_req && !mem_we && !per_rd));
    // R8
    fetch_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fetch && wsel == 2'd3 && cnt != '0) |=> in_xfer);
    // R10
    skip_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fetch && wsel == 2'd3 && cnt == '0) |=> !in_xfer);
    // R5
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_xfer && reg_we && reg_addr == 3'd1) |=> $stable(mdf));
endmodule

bind chain_dma dma_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .per_rd(per_rd), .per_wr(per_wr),
    .reg_we(reg_we), .reg_addr(reg_addr),
    .in_fetch(q.st == ST_FETCH), .in_xfer(q.st == ST_XFER),
    .wsel(q.wsel), .cnt(q.cnt), .mdf(q.mdf)
);

// File: tb/chain_dma_test.sv
module chain_dma_test;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          mem_req, mem_we, per_rd, per_wr, busy, irq;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata, per_rdata, per_wdata;

    logic [DW-1:0] mem [0:255];
    logic [AW-1:0] acc_addr [0:511];
    logic          acc_we [0:511];
    logic [DW-1:0] sink [0:511];
    int acc_n = 0, sink_n = 0, irq_n = 0, src_n = 0, cyc = 0;
    int n_chk = 0, n_err = 0;

    always #10 clk = ~clk;

    chain_dma #(.AW(AW), .DW(DW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .per_rd(per_rd), .per_rdata(per_rdata),
        .per_wr(per_wr), .per_wdata(per_wdata), .busy(busy), .irq(irq)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    assign per_rdata = 32'hA500_0000 | 32'(src_n);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req) begin
            if (acc_n < 512) begin
                acc_addr[acc_n] <= mem_addr;
                acc_we[acc_n]   <= mem_we;
            end
            acc_n <= acc_n + 1;
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        end
        if (per_wr) begin
            if (sink_n < 512) sink[sink_n] <= per_wdata;
            sink_n <= sink_n + 1;
        end
        if (per_rd) src_n <= src_n + 1;
        if (irq) irq_n <= irq_n + 1;
        if (cyc > 150000) begin
            n_err = n_err + 1;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
            $finish;
        end
    end

    function automatic logic [DW-1:0] init_val(int a);
        return 32'h1000_0000 ^ (32'(a) * 32'h0000_9E37);
    endfunction

    function automatic logic [AW-1:0] exp_addr(int idx, int mdf, int k);
        return AW'(idx + k * mdf);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_err = n_err + 1;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic fresh();
        @(negedge clk);
        for (int i = 0; i < 256; i++) mem[i] = init_val(i);
        acc_n = 0; sink_n = 0; irq_n = 0;
    endtask

    task automatic run_sa(input int idx, input int mdf, input int cnt,
                          input bit dir, input bit poke);
        logic [DW-1:0] v;
        int src0;
        fresh();
        wr(3'd0, DW'(idx)); wr(3'd1, DW'(mdf)); wr(3'd2, DW'(cnt));
        wr(3'd4, 32'd0);
        src0 = src_n;
        acc_n = 0; sink_n = 0; irq_n = 0;
        wr(3'd4, DW'({dir, 1'b0, 1'b1}));
        if (poke) begin
            // R5: writes while busy
            wr(3'd1, 32'd7); wr(3'd0, 32'h0033); wr(3'd2, 32'd99);
        end
        wait_idle();
        chk(acc_n == cnt, "R3 access count", 32'(acc_n), 32'(cnt));
        chk(irq_n == 1, "R7 one irq", 32'(irq_n), 32'd1);
        for (int k = 0; k < cnt; k++) begin
            logic [AW-1:0] a;
            a = exp_addr(idx, mdf, k);
            chk(acc_addr[k] == a && acc_we[k] == dir, "R3 address",
                DW'(acc_addr[k]), DW'(a));
            if (dir)
                chk(mem[a[7:0]] == (32'hA500_0000 | 32'(src0 + k)), "R4 to memory",
                    mem[a[7:0]], 32'hA500_0000 | 32'(src0 + k));
            else
                chk(sink[k] == init_val(int'(a[7:0])), "R4 to peripheral",
                    sink[k], init_val(int'(a[7:0])));
        end
        rd(3'd1, v);
        chk(v == DW'(mdf), "R5 modify kept", v, DW'(mdf));
        rd(3'd2, v);
        chk(v == 0, "R5 count drained", v, 0);
    endtask

    initial begin
        logic [DW-1:0] v;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) mem[i] = init_val(i);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 0 && irq == 0, "R1 flags", DW'({busy, irq}), 0);
        for (int r = 0; r < 5; r++) begin
            rd(3'(r), v);
            chk(v == 0, "R1 register zero", v, 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R2: readback while idle
        wr(3'd0, 32'h0012); rd(3'd0, v); chk(v == 32'h12, "R2 index", v, 32'h12);
        wr(3'd1, 32'h0003); rd(3'd1, v); chk(v == 32'h3, "R2 modify", v, 32'h3);
        wr(3'd2, 32'h0005); rd(3'd2, v); chk(v == 32'h5, "R2 count", v, 32'h5);
        wr(3'd3, 32'h0044); rd(3'd3, v); chk(v == 32'h44, "R2 chain", v, 32'h44);
        wr(3'd4, 32'h0004); rd(3'd4, v); chk(v == 32'h4, "R2 control", v, 32'h4);

        // R3 R4 directed
        run_sa(16, 2, 5, 1'b0, 1'b0);
        run_sa(32, 3, 4, 1'b1, 1'b0);
        // R5 writes while busy
        run_sa(8, 1, 8, 1'b0, 1'b1);

        // R6: enable rewritten without clearing
        acc_n = 0; irq_n = 0;
        wr(3'd2, 32'd4);
        wr(3'd4, 32'd1);
        repeat (6) @(negedge clk);
        chk(busy == 0 && acc_n == 0 && irq_n == 0, "R6 no restart",
            32'(acc_n), 0);

        // R7: count zero standalone
        wr(3'd4, 32'd0); wr(3'd2, 32'd0);
        acc_n = 0; irq_n = 0;
        wr(3'd4, 32'd1);
        chk(irq == 1 && busy == 0, "R7 zero count irq", DW'({irq, busy}), 32'h2);
        wait_idle();
        chk(acc_n == 0 && irq_n == 1, "R7 zero count no access", 32'(acc_n), 0);

        // random standalone runs
        for (int t = 0; t < 12; t++)
            run_sa(int'($urandom_range(127, 0)), int'($urandom_range(15, 1)),
                   int'($urandom_range(8, 1)), 1'($urandom_range(1, 0)), 1'b0);

        // R8 R9 R10 chained: D0 write 3 words, D1 count 0, D2 read 2 words
        fresh();
        mem[8'h40] = 32'h51; mem[8'h41] = 32'd3; mem[8'h42] = 32'd2; mem[8'h43] = 32'h80;
        mem[8'h50] = 32'h60; mem[8'h51] = 32'd0; mem[8'h52] = 32'd1; mem[8'h53] = 32'hC0;
        mem[8'h60] = 32'h00; mem[8'h61] = 32'd2; mem[8'h62] = 32'd3; mem[8'h63] = 32'h90;
        wr(3'd4, 32'd0); wr(3'd3, 32'h40);
        begin
            int src0;
            logic [AW-1:0] ea [0:16];
            bit ew [0:16];
            src0 = src_n;
            acc_n = 0; sink_n = 0; irq_n = 0;
            ea[0] = 16'h40; ea[1] = 16'h41; ea[2] = 16'h42; ea[3] = 16'h43;
            ea[4] = 16'h80; ea[5] = 16'h82; ea[6] = 16'h84;
            ea[7] = 16'h50; ea[8] = 16'h51; ea[9] = 16'h52; ea[10] = 16'h53;
            ea[11] = 16'h60; ea[12] = 16'h61; ea[13] = 16'h62; ea[14] = 16'h63;
            ea[15] = 16'h90; ea[16] = 16'h93;
            for (int i = 0; i < 17; i++) ew[i] = (i >= 4 && i <= 6);
            wr(3'd4, 32'd3);
            wait_idle();
            chk(acc_n == 17, "R8 chain access count", 32'(acc_n), 32'd17);
            for (int i = 0; i < 17; i++)
                chk(acc_addr[i] == ea[i] && acc_we[i] == ew[i], "R8 R10 access order",
                    DW'({acc_we[i], acc_addr[i]}), DW'({ew[i], ea[i]}));
            for (int k = 0; k < 3; k++)
                chk(mem[8'h80 + 2 * k] == (32'hA500_0000 | 32'(src0 + k)),
                    "R9 write descriptor data", mem[8'h80 + 2 * k],
                    32'hA500_0000 | 32'(src0 + k));
            chk(sink_n == 2 && sink[0] == init_val(8'h90) && sink[1] == init_val(8'h93),
                "R9 read descriptor data", sink[1], init_val(8'h93));
            chk(irq_n == 1, "R9 single irq at chain end", 32'(irq_n), 32'd1);
        end

        // R11: chained with zero pointer
        wr(3'd4, 32'd0); wr(3'd3, 32'd0);
        acc_n = 0; irq_n = 0;
        wr(3'd4, 32'd3);
        wait_idle();
        chk(acc_n == 0 && irq_n == 1, "R11 zero pointer", 32'(acc_n), 0);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule